// File: doc/BRIEF.md
# Serial Synthesizer Control Interface

This block is the programming front end of an integer-N frequency synthesizer. It takes a serial bit stream on a data line and a data clock and steers it into one of two shadow buffers. A select line decides which one. A 20-bit buffer feeds the divider control word and is committed by the rising edge of a load strobe. An 8-bit buffer feeds the option word and is committed when the select line falls. Bits arrive least significant first. The block decodes the committed divider word into a 6-bit reference divide value, a 9-bit main divide value, a 4-bit swallow count and a prescaler bypass flag.

A strap input chooses between the serial word and parallel divider pins. With the strap high, the three divide values come straight from the pins and bypass is held off. The option word drives a power-down flag and a counter-load flag. It also selects which internal divider tick is copied to a single debug pin. An active-low enable gates all of these option functions.

All serial controls are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. The dividers and the phase comparator sit outside this block.

Top module: `pll_serial_ctrl`

## Requirements
- R1: While reset is held and after it clears, the divide outputs, bypass, power-down, counter-load and debug outputs are all 0.
- R2: A data-clock rise with the select line low shifts one bit into the divider buffer. The divider outputs change only on a load strobe rise, three system clocks after the strobe is driven, and they hold through any amount of shifting without a strobe.
- R3: The committed divider word maps by arrival order (bit k is the k-th bit received): k0=ref[5], k1=ref[4], k2=main[8], k3=main[7], k4=bypass, k5..k11=main[6] down to main[0], k12..k15=ref[3] down to ref[0], k16..k19=swallow[3] down to swallow[0].
- R4: A data-clock rise with the select line high shifts into the option buffer. The option word is committed on the select line's falling edge, and these bits never reach the divider word.
- R5: With the direct strap high, the divide outputs equal the parallel pins and bypass is 0. Returning the strap low restores the committed serial word.
- R6: With the option enable high, power-down, counter-load and debug read 0 whatever the option word holds.
- R7: With the option enable low, power-down follows option bit 3 and counter-load follows option bit 4.
- R8: With the option enable low, debug copies the main divider tick if option bit 2 is set, the modulus select if bit 5 is set, and the reference tick if bit 6 is set.
- R9: When more than 20 bits are shifted before a strobe, only the last 20 received are committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial data clock, asynchronous |
| ser_dat | input | 1 | Serial data, least significant bit first |
| load_stb | input | 1 | Divider word commit strobe (rising edge) |
| enh_sel | input | 1 | Routes shifting to the option buffer; its fall commits |
| mode_dir | input | 1 | 1 = divide values from parallel pins |
| enh_en_n | input | 1 | Active-low enable of option functions |
| dir_r | input | 6 | Parallel reference divide value |
| dir_m | input | 9 | Parallel main divide value |
| dir_a | input | 4 | Parallel swallow count |
| main_tick | input | 1 | Main divider output tick |
| ref_tick | input | 1 | Reference divider output tick |
| mod_sel | input | 1 | Prescaler modulus select |
| div_r | output | 6 | Reference divide value |
| div_m | output | 9 | Main divide value |
| div_a | output | 4 | Swallow count |
| bypass | output | 1 | Prescaler bypass |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Continuous counter load request |
| dbg_out | output | 1 | Selected debug signal |

## Verification
A corrupted shift buffer stays hidden until the next commit. After that commit, one or more divide fields show wrong values on the third clock after the strobe. The scrambled field mapping makes a single misplaced bit show up as a change in a field that looks unrelated. A stale or early commit of the option word shows within three clocks of the select line falling, and only while the option enable is low: the debug pin then follows the wrong tick, or power-down or counter-load takes the wrong level. The reference model compares every output on every clock, so a divergence is reported in the cycle where it first appears.

// File: rtl/pll_ctrl_pkg.sv
`timescale 1ns/1ps
package pll_ctrl_pkg;
  localparam int R_W         = 6;
  localparam int M_W         = 9;
  localparam int A_W         = 4;
  localparam int FREQ_W      = 20;
  localparam int ENH_W       = 8;
  localparam int SYNC_STAGES = 2;
  localparam int RST_STAGES  = 2;

  // option word bit positions
  localparam int ENH_MAIN = 2;
  localparam int ENH_PD   = 3;
  localparam int ENH_LOAD = 4;
  localparam int ENH_MSEL = 5;
  localparam int ENH_REF  = 6;
  localparam int ENH_LO   = ENH_MAIN;
  localparam int ENH_HI   = ENH_REF;

  // synchroniser channel indices
  localparam int CH_CLK  = 0;
  localparam int CH_DAT  = 1;
  localparam int CH_LOAD = 2;
  localparam int CH_ENH  = 3;
  localparam int N_CH    = 4;

  typedef enum logic [1:0] {SYNC_LEVEL, SYNC_RISE, SYNC_FALL} sync_kind_e;

  typedef struct packed {
    logic [R_W-1:0] r;
    logic [M_W-1:0] m;
    logic [A_W-1:0] a;
    logic           bypass;
  } freq_fields_t;

  function automatic sync_kind_e chan_kind(int idx);
    return (idx == CH_CLK || idx == CH_LOAD) ? SYNC_RISE : SYNC_LEVEL;
  endfunction
endpackage

// File: rtl/pll_edge_sync.sv
`timescale 1ns/1ps
module pll_edge_sync
  import pll_ctrl_pkg::*;
#(
  parameter int         STAGES = 2,
  parameter sync_kind_e KIND   = SYNC_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic sig_o
);
  logic [STAGES-1:0] sq_q, sq_nx;

  always_comb begin
    sq_nx = {sq_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq_q <= '0;
    else        sq_q <= sq_nx;
  end

  generate
    if (KIND == SYNC_LEVEL) begin : g_level
      assign sig_o = sq_q[STAGES-1];
    end else begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sq_q[STAGES-1];
      end
      if (KIND == SYNC_RISE) begin : g_rise
        assign sig_o = sq_q[STAGES-1] & ~prev_q;
      end else begin : g_fall
        assign sig_o = ~sq_q[STAGES-1] & prev_q;
      end
    end
  endgenerate
endmodule

// File: rtl/pll_shadow_reg.sv
`timescale 1ns/1ps
module pll_shadow_reg #(
  parameter int WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             commit,
  output logic [WIDTH-1:0] word_q
);
  logic [WIDTH-1:0] sh_q, sh_nx, word_nx;

  always_comb begin
    sh_nx   = sh_q;
    word_nx = word_q;
    if (shift_en) sh_nx   = {bit_in, sh_q[WIDTH-1:1]};
    if (commit)   word_nx = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
    end else begin
      sh_q   <= sh_nx;
      word_q <= word_nx;
    end
  end
endmodule

// File: rtl/pll_freq_map.sv
`timescale 1ns/1ps
module pll_freq_map
  import pll_ctrl_pkg::*;
(
  input  logic [FREQ_W-1:0] word,
  input  logic              mode_dir,
  input  logic [R_W-1:0]    dir_r,
  input  logic [M_W-1:0]    dir_m,
  input  logic [A_W-1:0]    dir_a,
  output freq_fields_t      fld
);
  localparam int M_LOW_N  = M_W - 2;
  localparam int M_LOW_B  = 5;
  localparam int R_LOW_N  = R_W - 2;
  localparam int R_LOW_B  = M_LOW_B + M_LOW_N;
  localparam int A_B      = R_LOW_B + R_LOW_N;

  freq_fields_t ser_f;

  always_comb begin
    ser_f        = '0;
    ser_f.r[R_W-1] = word[0];
    ser_f.r[R_W-2] = word[1];
    ser_f.m[M_W-1] = word[2];
    ser_f.m[M_W-2] = word[3];
    ser_f.bypass   = word[4];
    for (int k = 0; k < M_LOW_N; k++) ser_f.m[M_LOW_N-1-k] = word[M_LOW_B+k];
    for (int k = 0; k < R_LOW_N; k++) ser_f.r[R_LOW_N-1-k] = word[R_LOW_B+k];
    for (int k = 0; k < A_W; k++)     ser_f.a[A_W-1-k]     = word[A_B+k];
  end

  always_comb begin
    if (mode_dir) begin
      fld.r      = dir_r;
      fld.m      = dir_m;
      fld.a      = dir_a;
      fld.bypass = 1'b0;
    end else begin
      fld = ser_f;
    end
  end
endmodule

// File: rtl/pll_enh_ctl.sv
`timescale 1ns/1ps
module pll_enh_ctl
  import pll_ctrl_pkg::*;
(
  input  logic [ENH_HI:ENH_LO] ctl_bits,
  input  logic                 enh_en_n,
  input  logic                 main_tick,
  input  logic                 ref_tick,
  input  logic                 mod_sel,
  output logic                 pwr_down,
  output logic                 cnt_load,
  output logic                 dbg_out
);
  logic [ENH_HI:ENH_LO] act;

  assign act      = enh_en_n ? '0 : ctl_bits;
  assign pwr_down = act[ENH_PD];
  assign cnt_load = act[ENH_LOAD];
  assign dbg_out  = (act[ENH_MAIN] & main_tick) |
                    (act[ENH_MSEL] & mod_sel)   |
                    (act[ENH_REF]  & ref_tick);
endmodule

// File: rtl/pll_serial_ctrl.sv
`timescale 1ns/1ps
module pll_serial_ctrl
  import pll_ctrl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_clk,
  input  logic           ser_dat,
  input  logic           load_stb,
  input  logic           enh_sel,
  input  logic           mode_dir,
  input  logic           enh_en_n,
  input  logic [R_W-1:0] dir_r,
  input  logic [M_W-1:0] dir_m,
  input  logic [A_W-1:0] dir_a,
  input  logic           main_tick,
  input  logic           ref_tick,
  input  logic           mod_sel,
  output logic [R_W-1:0] div_r,
  output logic [M_W-1:0] div_m,
  output logic [A_W-1:0] div_a,
  output logic           bypass,
  output logic           pwr_down,
  output logic           cnt_load,
  output logic           dbg_out
);
  // reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[RST_STAGES-1];

  // synchronise the serial controls
  logic [N_CH-1:0] raw_in, syn_out;
  assign raw_in[CH_CLK]  = ser_clk;
  assign raw_in[CH_DAT]  = ser_dat;
  assign raw_in[CH_LOAD] = load_stb;
  assign raw_in[CH_ENH]  = enh_sel;

  for (genvar g = 0; g < N_CH; g++) begin : g_sync
    pll_edge_sync #(
      .STAGES (SYNC_STAGES),
      .KIND   (chan_kind(g))
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_ni),
      .din   (raw_in[g]),
      .sig_o (syn_out[g])
    );
  end

  logic clk_rise, dat_lvl, load_rise, enh_lvl, enh_d_q, enh_fall;
  assign clk_rise  = syn_out[CH_CLK];
  assign dat_lvl   = syn_out[CH_DAT];
  assign load_rise = syn_out[CH_LOAD];
  assign enh_lvl   = syn_out[CH_ENH];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) enh_d_q <= 1'b0;
    else         enh_d_q <= enh_lvl;
  end
  assign enh_fall = enh_d_q & ~enh_lvl;

  logic freq_shift, enh_shift;
  assign freq_shift = clk_rise & ~enh_lvl;
  assign enh_shift  = clk_rise &  enh_lvl;

  logic [FREQ_W-1:0] freq_word;
  logic [ENH_W-1:0]  enh_word;

  pll_shadow_reg #(.WIDTH(FREQ_W)) u_freq_sh (
    .clk      (clk),
    .rst_n    (rst_ni),
    .shift_en (freq_shift),
    .bit_in   (dat_lvl),
    .commit   (load_rise),
    .word_q   (freq_word)
  );

  pll_shadow_reg #(.WIDTH(ENH_W)) u_enh_sh (
    .clk      (clk),
    .rst_n    (rst_ni),
    .shift_en (enh_shift),
    .bit_in   (dat_lvl),
    .commit   (enh_fall),
    .word_q   (enh_word)
  );

  freq_fields_t fld;

  pll_freq_map u_map (
    .word     (freq_word),
    .mode_dir (mode_dir),
    .dir_r    (dir_r),
    .dir_m    (dir_m),
    .dir_a    (dir_a),
    .fld      (fld)
  );

  assign div_r  = fld.r;
  assign div_m  = fld.m;
  assign div_a  = fld.a;
  assign bypass = fld.bypass;

  pll_enh_ctl u_enh (
    .ctl_bits  (enh_word[ENH_HI:ENH_LO]),
    .enh_en_n  (enh_en_n),
    .main_tick (main_tick),
    .ref_tick  (ref_tick),
    .mod_sel   (mod_sel),
    .pwr_down  (pwr_down),
    .cnt_load  (cnt_load),
    .dbg_out   (dbg_out)
  );
endmodule

// File: rtl/pll_serial_ctrl_chk.sv
`timescale 1ns/1ps
module pll_serial_ctrl_chk
  import pll_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mode_dir,
  input logic              enh_en_n,
  input logic              main_tick,
  input logic              bypass,
  input logic              pwr_down,
  input logic              cnt_load,
  input logic              dbg_out,
  input logic              load_rise,
  input logic              enh_fall,
  input logic [FREQ_W-1:0] freq_word,
  input logic [ENH_W-1:0]  enh_word
);
  assert_freq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(freq_word))
    else $error("divider word changed without a strobe");

  assert_enh_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_fall |=> $stable(enh_word))
    else $error("option word changed without select fall");

  assert_direct_no_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_dir |-> !bypass)
    else $error("bypass set in direct mode");

  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    enh_en_n |-> (!pwr_down && !cnt_load && !dbg_out))
    else $error("option function active while disabled");

  assert_dbg_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_en_n && enh_word == 8'h04) |-> (dbg_out == main_tick))
    else $error("debug pin not following main tick");
endmodule

bind pll_serial_ctrl pll_serial_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_dir  (mode_dir),
  .enh_en_n  (enh_en_n),
  .main_tick (main_tick),
  .bypass    (bypass),
  .pwr_down  (pwr_down),
  .cnt_load  (cnt_load),
  .dbg_out   (dbg_out),
  .load_rise (load_rise),
  .enh_fall  (enh_fall),
  .freq_word (freq_word),
  .enh_word  (enh_word)
);

// File: tb/pll_serial_ctrl_bench.sv
`timescale 1ns/1ps
module pll_serial_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, load_stb = 1'b0, enh_sel = 1'b0;
  logic       mode_dir = 1'b0, enh_en_n = 1'b1;
  logic [5:0] dir_r = '0;
  logic [8:0] dir_m = '0;
  logic [3:0] dir_a = '0;
  logic       main_tick = 1'b0, ref_tick = 1'b0, mod_sel = 1'b0;
  logic [5:0] div_r;
  logic [8:0] div_m;
  logic [3:0] div_a;
  logic       bypass, pwr_down, cnt_load, dbg_out;

  always #2.5 clk = ~clk;

  pll_serial_ctrl u_pll_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .load_stb(load_stb), .enh_sel(enh_sel), .mode_dir(mode_dir),
    .enh_en_n(enh_en_n), .dir_r(dir_r), .dir_m(dir_m), .dir_a(dir_a),
    .main_tick(main_tick), .ref_tick(ref_tick), .mod_sel(mod_sel),
    .div_r(div_r), .div_m(div_m), .div_a(div_a), .bypass(bypass),
    .pwr_down(pwr_down), .cnt_load(cnt_load), .dbg_out(dbg_out)
  );

  // behavioural reference model
  bit          fq[$];
  bit          eq[$];
  logic [19:0] fw = '0;
  logic [7:0]  ew = '0;
  int          n_chk = 0, n_err = 0;
  bit          chk_on = 1'b0, done = 1'b0;
  string       cur_req = "R1";
  int unsigned tick_cnt = 0;

  always @(negedge clk) begin
    tick_cnt  = tick_cnt + 1;
    main_tick = tick_cnt[0];
    ref_tick  = tick_cnt[1];
    mod_sel   = tick_cnt[3];
  end

  always @(posedge clk) begin
    #1;
    if (chk_on && !done) begin
      logic [5:0] er; logic [8:0] em; logic [3:0] ea; logic eb;
      logic [7:0] act; logic ep, el, ed;
      if (mode_dir) begin
        er = dir_r; em = dir_m; ea = dir_a; eb = 1'b0;
      end else begin
        er = {fw[0], fw[1], fw[12], fw[13], fw[14], fw[15]};
        em = {fw[2], fw[3], fw[5], fw[6], fw[7], fw[8], fw[9], fw[10], fw[11]};
        ea = {fw[16], fw[17], fw[18], fw[19]};
        eb = fw[4];
      end
      act = enh_en_n ? 8'h00 : ew;
      ep  = act[3];
      el  = act[4];
      ed  = (act[2] & main_tick) | (act[5] & mod_sel) | (act[6] & ref_tick);
      n_chk++;
      if (div_r !== er || div_m !== em || div_a !== ea || bypass !== eb ||
          pwr_down !== ep || cnt_load !== el || dbg_out !== ed) begin
        n_err++;
        $display("FAIL %s: got r=%0d m=%0d a=%0d byp=%0b pd=%0b ld=%0b dbg=%0b expected r=%0d m=%0d a=%0d byp=%0b pd=%0b ld=%0b dbg=%0b",
                 cur_req, div_r, div_m, div_a, bypass, pwr_down, cnt_load, dbg_out,
                 er, em, ea, eb, ep, el, ed);
      end
    end
  end

  task automatic pause(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    ser_dat = b;
    pause(3);
    ser_clk = 1'b1;
    if (enh_sel) eq.push_back(b); else fq.push_back(b);
    pause(3);
    ser_clk = 1'b0;
    pause(3);
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = 0; i < n; i++) send_bit(w[i]);
  endtask

  task automatic pulse_load();
    chk_on   = 1'b0;
    load_stb = 1'b1;
    pause(5);
    for (int i = 0; i < 20; i++) fw[i] = fq[fq.size() - 20 + i];
    chk_on   = 1'b1;
    load_stb = 1'b0;
    pause(4);
  endtask

  task automatic write_enh(logic [7:0] v);
    enh_sel = 1'b1;
    pause(4);
    send_bits({24'h0, v}, 8);
    chk_on  = 1'b0;
    enh_sel = 1'b0;
    pause(5);
    for (int i = 0; i < 8; i++) ew[i] = eq[eq.size() - 8 + i];
    chk_on  = 1'b1;
    pause(4);
  endtask

  initial begin
    for (int i = 0; i < 20; i++) fq.push_back(1'b0);
    for (int i = 0; i < 8; i++)  eq.push_back(1'b0);
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_on = 1'b1;
    pause(4);
    rst_n = 1'b1;
    pause(6);

    // R3 / R2: random words, field mapping and commit on strobe
    cur_req = "R3";
    for (int k = 0; k < 6; k++) begin
      send_bits({12'h0, 20'($urandom)}, 20);
      pulse_load();
    end
    cur_req = "R3";
    send_bits(32'h000F_FFFF, 20);
    pulse_load();
    send_bits(32'h0000_0001, 20);
    pulse_load();

    // R2: shifting without a strobe leaves outputs alone
    cur_req = "R2";
    send_bits({12'h0, 20'($urandom)}, 20);
    pause(10);
    pulse_load();

    // R9: 27 bits before the strobe, last 20 win
    cur_req = "R9";
    send_bits({5'h0, 27'($urandom)}, 27);
    pulse_load();

    // R5: direct mode overrides, bypass forced off
    cur_req = "R5";
    send_bits(32'h0005_5A5F, 20);
    pulse_load();
    for (int k = 0; k < 4; k++) begin
      mode_dir = 1'b1;
      dir_r = 6'($urandom); dir_m = 9'($urandom); dir_a = 4'($urandom);
      pause(6);
    end
    mode_dir = 1'b0;
    pause(6);

    // R4 / R7: option word commit, divider word untouched
    cur_req = "R4";
    enh_en_n = 1'b0;
    write_enh(8'h08);
    cur_req = "R7";
    pause(8);
    write_enh(8'h10);
    pause(8);

    // R6: disable hides the option functions
    cur_req = "R6";
    enh_en_n = 1'b1;
    write_enh(8'h18);
    pause(8);
    write_enh(8'h40);
    pause(8);
    enh_en_n = 1'b0;

    // R8: debug routing of each source
    cur_req = "R8";
    write_enh(8'h04);
    pause(16);
    write_enh(8'h20);
    pause(24);
    write_enh(8'h40);
    pause(16);
    write_enh(8'h00);
    pause(8);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule